// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Operand Assembler

This block sits at the front of a stack-machine pipeline. It reads a plain byte stream from code memory, one byte per accepted transfer, and splits it into instructions. Each instruction begins with an opcode byte, and that byte alone decides how many operand bytes follow: none, one, two or four. A group of opcodes carries a 4-bit operand in its own low nibble, so small constants and short procedure numbers cost a single byte.

The program counter steps forward on every byte accepted, whether that byte is an opcode or an operand. A finished instruction is presented to the execution stage on a registered valid/ready interface. It carries the opcode byte, its length class, a zero-extended 32-bit immediate and the address of the byte that follows it. A branch input loads a new program counter. It throws away any half-gathered instruction and any instruction still waiting downstream.

Top module: `vlf_fetch`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `code_addr` equals `RESET_PC` (default 0).
- R2: The length class depends on opcode bits [7:5]. 000 and 001 are nibble forms with no operand bytes. 010, 011 and 111 have no operand bytes and an immediate of 0. 100 takes one operand byte, 101 takes two and 110 takes four. `out_len` reports these as 0 (none), 1 (one byte), 2 (two bytes) and 3 (four bytes).
- R3: In a nibble-form opcode, `out_imm` equals opcode bits [3:0] zero-extended. For example, 0x05 gives 5 and 0x1F gives 15.
- R4: A one-byte operand is zero-extended. For example, 0x80 0x99 gives an immediate of 153.
- R5: A two-byte operand is assembled least significant byte first. For example, 0xA0 0x34 0x12 gives 0x1234.
- R6: A four-byte operand is assembled least significant byte first. For example, 0xC0 0x78 0x56 0x34 0x12 gives 0x12345678.
- R7: `code_addr` advances by one on every cycle in which `code_valid` and `code_ready` are both high. `out_pc` is the address just past the last byte of the presented instruction.
- R8: An instruction is presented only after all of its operand bytes have been accepted. Gaps in `code_valid` change neither the result nor the order.
- R9: While `out_valid` is high and `out_ready` is low, `code_ready` is 0, `code_addr` holds, and the presented instruction stays unchanged.
- R10: A cycle with `br_valid` high loads `br_target` into `code_addr`. It drops any partly gathered instruction and any presented one, so `out_valid` is 0 on the next cycle. Fetching restarts at the target with a fresh opcode.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_addr | output | ADDR_W | Address of the next code byte wanted (program counter) |
| code_byte | input | 8 | Code byte at `code_addr` |
| code_valid | input | 1 | `code_byte` is valid this cycle |
| code_ready | output | 1 | Decoder accepts the byte this cycle |
| br_valid | input | 1 | Load a new program counter |
| br_target | input | ADDR_W | New program counter |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | Execution stage takes the instruction |
| out_op | output | 8 | Opcode byte |
| out_len | output | 2 | Length class (0 none, 1 one, 2 two, 3 four bytes) |
| out_imm | output | 8*OPND_MAX | Zero-extended immediate |
| out_pc | output | ADDR_W | Address following the instruction |

## Verification
Two events can land in the same cycle and must be resolved: a branch, and either an instruction waiting on a stalled execution stage or an operand gathering that is half done. Both cases are set up on purpose. In the first, the branch is raised while `out_ready` is held low with a complete four-byte instruction presented. In the second, the branch is raised after two bytes of a four-byte instruction have been taken. The bench then requires that `out_valid` falls in the next cycle, that `code_addr` equals the target, and that the first instruction collected afterwards is the one at the target, with the correct immediate and next-address.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  typedef enum logic [1:0] {
    LEN_NONE = 2'd0,
    LEN_ONE  = 2'd1,
    LEN_TWO  = 2'd2,
    LEN_FOUR = 2'd3
  } len_e;

  typedef struct packed {
    logic nib;
    len_e len;
  } op_info_t;
endpackage

// File: rtl/vlf_len_table.sv
// Opcode length lookup: 256 opcodes mapped by their top three bits.
module vlf_len_table
  import vlf_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);
  always_comb begin
    info.nib = 1'b0;
    info.len = LEN_NONE;
    unique case (op[7:5])
      3'b000, 3'b001: info.nib = 1'b1;
      3'b100:         info.len = LEN_ONE;
      3'b101:         info.len = LEN_TWO;
      3'b110:         info.len = LEN_FOUR;
      default:        info.len = LEN_NONE;
    endcase
  end
endmodule

// File: rtl/vlf_opnd_asm.sv
// Operand gatherer: places each pushed byte at the next byte lane, LSB first.
module vlf_opnd_asm #(
  parameter int BYTES = 4,
  localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [7:0]        din,
  output logic [IW-1:0]     idx,
  output logic [8*BYTES-1:0] merged
);
  logic [IW-1:0]      idx_q;
  logic [8*BYTES-1:0] acc_q;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign merged[8*g +: 8] = (idx_q == IW'(g)) ? din : acc_q[8*g +: 8];
  end

  assign idx = idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (push) begin
      idx_q <= idx_q + 1'b1;
      acc_q <= merged;
    end
  end
endmodule

// File: rtl/vlf_fetch.sv
module vlf_fetch
  import vlf_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter int          OPND_MAX = 4,
  localparam int IMM_W = 8 * OPND_MAX,
  localparam int IW    = (OPND_MAX > 1) ? $clog2(OPND_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] code_addr,
  input  logic [7:0]        code_byte,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_target,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_op,
  output logic [1:0]        out_len,
  output logic [IMM_W-1:0]  out_imm,
  output logic [ADDR_W-1:0] out_pc
);
  typedef enum logic {S_OP, S_OPND} st_e;

  st_e               st;
  logic [ADDR_W-1:0] pc;
  logic [7:0]        op_q;
  len_e              len_q;
  logic [IW-1:0]     last_q;
  op_info_t          info;
  logic              take, asm_clr, asm_push;
  logic [IW-1:0]     asm_idx;
  logic [IMM_W-1:0]  asm_val;
  logic [IW-1:0]     last_n;

  vlf_len_table u_tbl (.op(code_byte), .info(info));

  assign code_ready = (!out_valid || out_ready) && !br_valid;
  assign take       = code_valid && code_ready;
  assign asm_clr    = br_valid || (take && st == S_OP);
  assign asm_push   = take && st == S_OPND;
  assign code_addr  = pc;

  vlf_opnd_asm #(.BYTES(OPND_MAX)) u_asm (
    .clk(clk), .rst(rst), .clr(asm_clr), .push(asm_push),
    .din(code_byte), .idx(asm_idx), .merged(asm_val)
  );

  always_comb begin
    unique case (info.len)
      LEN_ONE:  last_n = IW'(0);
      LEN_TWO:  last_n = IW'(1);
      default:  last_n = IW'(OPND_MAX - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= ADDR_W'(RESET_PC);
      st        <= S_OP;
      out_valid <= 1'b0;
      out_op    <= '0;
      out_len   <= '0;
      out_imm   <= '0;
      out_pc    <= '0;
      op_q      <= '0;
      len_q     <= LEN_NONE;
      last_q    <= '0;
    end else if (br_valid) begin
      pc        <= br_target;
      st        <= S_OP;
      out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        pc <= pc + 1'b1;
        if (st == S_OP) begin
          if (info.len == LEN_NONE) begin
            out_valid <= 1'b1;
            out_op    <= code_byte;
            out_len   <= LEN_NONE;
            out_imm   <= info.nib ? IMM_W'(code_byte[3:0]) : '0;
            out_pc    <= pc + 1'b1;
          end else begin
            op_q   <= code_byte;
            len_q  <= info.len;
            last_q <= last_n;
            st     <= S_OPND;
          end
        end else if (asm_idx == last_q) begin
          out_valid <= 1'b1;
          out_op    <= op_q;
          out_len   <= len_q;
          out_imm   <= asm_val;
          out_pc    <= pc + 1'b1;
          st        <= S_OP;
        end
      end
    end
  end
endmodule

// File: rtl/vlf_fetch_chk.sv
module vlf_fetch_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter int          OPND_MAX = 4,
  localparam int IMM_W = 8 * OPND_MAX
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] code_addr,
  input logic [7:0]        code_byte,
  input logic              code_valid,
  input logic              code_ready,
  input logic              br_valid,
  input logic [ADDR_W-1:0] br_target,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_op,
  input logic [1:0]        out_len,
  input logic [IMM_W-1:0]  out_imm,
  input logic [ADDR_W-1:0] out_pc
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> !out_valid && code_addr == ADDR_W'(RESET_PC));

  a_r3_nibble_imm: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_op[7:6] == 2'b00 |-> out_imm == IMM_W'(out_op[3:0]));

  a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
    code_valid && code_ready |=> code_addr == $past(code_addr) + 1'b1);

  a_r9_hold_out: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !br_valid |=>
      out_valid && $stable(out_imm) && $stable(out_op) && $stable(out_pc) && $stable(code_addr));

  a_r9_no_take: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !code_ready);

  a_r10_branch: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> !out_valid && code_addr == $past(br_target));
endmodule

bind vlf_fetch vlf_fetch_chk #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC), .OPND_MAX(OPND_MAX)) u_chk (.*);

// File: tb/sim_vlf_fetch.sv
`timescale 1ns/1ps
module sim_vlf_fetch;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] code_addr, br_target, out_pc;
  logic [7:0] code_byte, out_op;
  logic code_valid, code_ready, br_valid, out_valid, out_ready;
  logic [1:0] out_len;
  logic [31:0] out_imm;
  logic [7:0] mem [256];

  int checks = 0, errors = 0, cyc = 0, ncap = 0;
  logic [7:0]    cap_op  [16];
  logic [31:0]   cap_imm [16];
  logic [AW-1:0] cap_pc  [16];
  logic [1:0]    cap_len [16];

  always #2 clk = ~clk;
  assign code_byte = mem[code_addr[7:0]];

  vlf_fetch u0 (
    .clk(clk), .rst(rst), .code_addr(code_addr), .code_byte(code_byte),
    .code_valid(code_valid), .code_ready(code_ready), .br_valid(br_valid),
    .br_target(br_target), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_len(out_len), .out_imm(out_imm), .out_pc(out_pc)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst && out_valid && out_ready && ncap < 16) begin
      cap_op[ncap]  = out_op;
      cap_imm[ncap] = out_imm;
      cap_pc[ncap]  = out_pc;
      cap_len[ncap] = out_len;
      ncap++;
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_plain();
    for (int i = 0; i < 256; i++) mem[i] = 8'h40;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; code_valid = 1'b0; br_valid = 1'b0; out_ready = 1'b1; br_target = '0;
    repeat (3) @(negedge clk);
    ncap = 0;
    rst = 1'b0;
  endtask

  task automatic load_mix();
    fill_plain();
    mem[0] = 8'h05;
    mem[1] = 8'h80; mem[2] = 8'h99;
    mem[3] = 8'hA0; mem[4] = 8'h34; mem[5] = 8'h12;
    mem[6] = 8'hC0; mem[7] = 8'h78; mem[8] = 8'h56; mem[9] = 8'h34; mem[10] = 8'h12;
    mem[11] = 8'h45; mem[12] = 8'h1F; mem[13] = 8'hE5;
  endtask

  task automatic check_mix(input string tag);
    chk({tag, " R1 count"}, 32'(ncap >= 7), 32'd1);
    chk({tag, " R3 op0 imm"}, cap_imm[0], 32'd5);
    chk({tag, " R7 op0 pc"}, 32'(cap_pc[0]), 32'd1);
    chk({tag, " R4 op1 imm"}, cap_imm[1], 32'd153);
    chk({tag, " R2 op1 len"}, 32'(cap_len[1]), 32'd1);
    chk({tag, " R7 op1 pc"}, 32'(cap_pc[1]), 32'd3);
    chk({tag, " R5 op2 imm"}, cap_imm[2], 32'h1234);
    chk({tag, " R2 op2 len"}, 32'(cap_len[2]), 32'd2);
    chk({tag, " R6 op3 imm"}, cap_imm[3], 32'h12345678);
    chk({tag, " R2 op3 len"}, 32'(cap_len[3]), 32'd3);
    chk({tag, " R7 op3 pc"}, 32'(cap_pc[3]), 32'd11);
    chk({tag, " R2 op4 imm"}, cap_imm[4], 32'd0);
    chk({tag, " R3 op5 imm"}, cap_imm[5], 32'd15);
    chk({tag, " R2 op6 op"}, 32'(cap_op[6]), 32'hE5);
    chk({tag, " R2 op6 imm"}, cap_imm[6], 32'd0);
    chk({tag, " R7 op6 pc"}, 32'(cap_pc[6]), 32'd14);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset code_addr", 32'(code_addr), 32'd0);
  endtask

  task automatic t_stream();
    load_mix();
    do_reset();
    code_valid = 1'b1;
    repeat (20) @(negedge clk);
    check_mix("stream");
  endtask

  task automatic t_gaps();
    load_mix();
    do_reset();
    for (int i = 0; i < 60; i++) begin
      code_valid = (i % 3) != 0;
      @(negedge clk);
    end
    check_mix("gaps R8");
  endtask

  task automatic t_stall();
    logic [31:0] held;
    logic [AW-1:0] addr;
    load_mix();
    do_reset();
    out_ready = 1'b0;
    code_valid = 1'b1;
    while (!out_valid) @(negedge clk);
    held = out_imm; addr = code_addr;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 7) begin
        chk("R9 stall code_ready", 32'(code_ready), 32'd0);
        chk("R9 stall imm", out_imm, held);
        chk("R9 stall addr", 32'(code_addr), 32'(addr));
        chk("R9 stall valid", 32'(out_valid), 32'd1);
      end
    end
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    check_mix("stall R9");
  endtask

  task automatic t_branch_partial();
    fill_plain();
    mem[0] = 8'hC0; mem[1] = 8'h11; mem[2] = 8'h22; mem[3] = 8'h33; mem[4] = 8'h44;
    mem[8'h20] = 8'h83; mem[8'h21] = 8'h07;
    do_reset();
    code_valid = 1'b1;
    while (code_addr != 16'd2) @(negedge clk);
    br_valid = 1'b1; br_target = 16'h0020;
    @(negedge clk);
    br_valid = 1'b0;
    chk("R10 partial out_valid", 32'(out_valid), 32'd0);
    chk("R10 partial addr", 32'(code_addr), 32'h20);
    repeat (6) @(negedge clk);
    chk("R10 partial first op", 32'(cap_op[0]), 32'h83);
    chk("R10 partial first imm", cap_imm[0], 32'd7);
    chk("R10 partial first pc", 32'(cap_pc[0]), 32'h22);
  endtask

  task automatic t_branch_pending();
    do_reset();
    out_ready = 1'b0;
    code_valid = 1'b1;
    while (!out_valid) @(negedge clk);
    br_valid = 1'b1; br_target = 16'h0020;
    @(negedge clk);
    br_valid = 1'b0;
    chk("R10 pending out_valid", 32'(out_valid), 32'd0);
    chk("R10 pending addr", 32'(code_addr), 32'h20);
    out_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 pending dropped op", 32'(cap_op[0]), 32'h83);
    chk("R10 pending imm", cap_imm[0], 32'd7);
  endtask

  initial begin
    code_valid = 1'b0; br_valid = 1'b0; out_ready = 1'b1; br_target = '0;
    fill_plain();
    t_reset();
    t_stream();
    t_gaps();
    t_stall();
    t_branch_partial();
    t_branch_pending();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule